// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision floating-point words and returns a registered 32-bit sum. Each word is split into a sign, an 8-bit biased exponent and a 27-bit working significand. The working significand is the 23 stored fraction bits with the hidden leading one restored above them, plus three zero bits appended below them. The operand with the smaller magnitude is shifted right by the exponent difference. Any bits that fall off the bottom during this shift are folded into the lowest bit, which then acts as a sticky bit. The two significands are then added, or subtracted when the signs differ. The result is normalised and rounded according to a one-bit rounding-mode input.

The adder is used as a one-cycle stage. The caller presents both operands, the rounding mode and a valid strobe in one cycle. The sum and a matching valid appear on the next cycle. When no valid strobe is given, the result register keeps its value. Only normal numbers and zero are handled. The caller keeps the operands in a range where the sum is also a normal number or zero.

Top module: `fpadd_top`

## Requirements
- R1: The operand fields are taken as follows: sign from bit 31, biased exponent from bits 30..23, fraction from bits 22..0. An exponent field of zero means the value zero, with no hidden one. Any other exponent field restores a hidden one above the fraction.
- R2: When both operand signs are equal, the result magnitude is the sum of the magnitudes, and the result has that common sign.
- R3: When the operand signs differ, the smaller magnitude is subtracted from the larger, and the result has the sign of the larger-magnitude operand.
- R4: The operand with the smaller exponent is aligned to the larger exponent. Bits shifted past the lowest working bit still count when the result is rounded (sticky behaviour).
- R5: A carry out of the significand add shifts the result right by one and raises the exponent by one. Leading zeros after a subtraction are removed by shifting left, and the exponent drops by the same amount.
- R6: With rndMode = 0, the result is rounded to the nearest representable value, and an exact tie goes to the value with an even last fraction bit.
- R7: With rndMode = 1, the discarded bits are dropped, so the magnitude is truncated toward zero.
- R8: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one.
- R9: Every result that is exactly zero is returned as +0 (word 0x00000000). This includes x + (-x), 0 + 0 and -0 + -0.
- R10: outValid is high exactly one cycle after a cycle with inValid high, and low otherwise. In a cycle without inValid, the result output keeps its previous value.
- R11: While rstN is low, outValid is 0 and the result is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word |
| rndMode | input | 1 | 0: nearest with ties to even, 1: toward zero |
| inValid | input | 1 | Operands and mode are presented this cycle |
| result | output | 32 | Registered sum word |
| outValid | output | 1 | result holds the sum of the previous cycle's operands |

## Verification
Every sum is due exactly one clock edge after the cycle in which its operands were presented with inValid high. The same edge raises outValid, and after the edge that follows, outValid falls again unless a new operand pair was presented. The bench drives each operand pair on a falling edge and compares on the next falling edge. At that point the result register has been loaded once and has settled. The expected word comes from an exact wide-integer sum that is rounded behaviourally. Idle cycles are compared the same way, against the word that was held before.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  // Rounding selections seen on the rndMode pin
  typedef enum logic {
    RND_NEAREST_EVEN = 1'b0,
    RND_TOWARD_ZERO  = 1'b1
  } rndMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadRes;       // capture the new sum this edge
    logic roundNearest;  // resolve extra bits by nearest-even, else drop them
  } ctrlStrobe_t;

endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        rndMode,
  output ctrlStrobe_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.loadRes      = inValid;
    strobes.roundNearest = (rndMode == RND_NEAREST_EVEN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R10: valid appears one edge after the input strobe
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R10: no strobe, no valid
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRS_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [EXP_W+MAN_W:0]     opA,
  input  logic [EXP_W+MAN_W:0]     opB,
  input  ctrlStrobe_t              strobes,
  output logic [EXP_W+MAN_W:0]     resWord
);

  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1 + GRS_W;
  localparam int SUM_W  = SIG_W + 1;
  localparam int LZ_W   = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] SIG_W_E = EXP_W'(SIG_W);

  // ---------------- unpack both operands ----------------
  logic [WORD_W-1:0] opWord [2];
  logic              opSign [2];
  logic [EXP_W-1:0]  opExp  [2];
  logic [SIG_W-1:0]  opSig  [2];

  assign opWord[0] = opA;
  assign opWord[1] = opB;

  for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
    assign opSign[gi] = opWord[gi][WORD_W-1];
    assign opExp[gi]  = opWord[gi][WORD_W-2:MAN_W];
    // hidden one only for a nonzero exponent field (R1)
    assign opSig[gi]  = {(|opWord[gi][WORD_W-2:MAN_W]), opWord[gi][MAN_W-1:0], {GRS_W{1'b0}}};
  end

  // ---------------- order by magnitude ----------------
  logic             aIsBig;
  logic             bigSign;
  logic [EXP_W-1:0] bigExp, smallExp, expDiff;
  logic [SIG_W-1:0] bigSig, smallSig;

  assign aIsBig   = {opExp[0], opSig[0]} >= {opExp[1], opSig[1]};
  assign bigSign  = aIsBig ? opSign[0] : opSign[1];
  assign bigExp   = aIsBig ? opExp[0]  : opExp[1];
  assign bigSig   = aIsBig ? opSig[0]  : opSig[1];
  assign smallExp = aIsBig ? opExp[1]  : opExp[0];
  assign smallSig = aIsBig ? opSig[1]  : opSig[0];
  assign expDiff  = bigExp - smallExp;

  // ---------------- alignment with sticky ----------------
  logic [SIG_W-1:0] alignSig;
  logic             lostBits;

  always_comb begin
    if (expDiff >= SIG_W_E) begin
      lostBits = |smallSig;
      alignSig = '0;
    end else begin
      lostBits = |(smallSig & ~({SIG_W{1'b1}} << expDiff));
      alignSig = smallSig >> expDiff;
    end
    alignSig[0] = alignSig[0] | lostBits;
  end

  // ---------------- add or subtract ----------------
  logic             effSub;
  logic [SUM_W-1:0] rawSum;
  logic             sumZero;

  assign effSub  = opSign[0] ^ opSign[1];
  assign rawSum  = effSub ? ({1'b0, bigSig} - {1'b0, alignSig})
                          : ({1'b0, bigSig} + {1'b0, alignSig});
  assign sumZero = (rawSum == '0);

  // ---------------- leading zero count ----------------
  logic [LZ_W-1:0] lzCnt;
  logic            lzFound;

  always_comb begin
    lzCnt   = '0;
    lzFound = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!lzFound && rawSum[i]) begin
        lzCnt   = LZ_W'(SIG_W - 1 - i);
        lzFound = 1'b1;
      end
    end
  end

  // ---------------- normalise ----------------
  logic [SIG_W-1:0] normSig;
  logic [EXP_W-1:0] normExp;

  always_comb begin
    if (rawSum[SIG_W]) begin
      normSig = rawSum[SIG_W:1] | {{(SIG_W-1){1'b0}}, rawSum[0]};
      normExp = bigExp + 1'b1;
    end else begin
      normSig = rawSum[SIG_W-1:0] << lzCnt;
      normExp = bigExp - EXP_W'(lzCnt);
    end
  end

  // ---------------- round ----------------
  logic [MAN_W:0]   keepSig;
  logic             guardBit, tailBits, roundUp;
  logic [MAN_W+1:0] roundSum;
  logic [MAN_W-1:0] finalMan;
  logic [EXP_W-1:0] finalExp;
  logic [WORD_W-1:0] nextWord;

  assign keepSig  = normSig[SIG_W-1:GRS_W];
  assign guardBit = normSig[GRS_W-1];
  assign tailBits = |normSig[GRS_W-2:0];
  assign roundUp  = strobes.roundNearest & guardBit & (tailBits | keepSig[0]);
  assign roundSum = {1'b0, keepSig} + {{(MAN_W+1){1'b0}}, roundUp};

  always_comb begin
    if (roundSum[MAN_W+1]) begin
      finalMan = roundSum[MAN_W:1];
      finalExp = normExp + 1'b1;
    end else begin
      finalMan = roundSum[MAN_W-1:0];
      finalExp = normExp;
    end
  end

  assign nextWord = sumZero ? '0 : {bigSign, finalExp, finalMan};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                resWord <= '0;
    else if (strobes.loadRes) resWord <= nextWord;
  end

  // R10: result register holds when nothing is loaded
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadRes |=> $stable(resWord));

  // R9: an exactly cancelled sum leaves +0 in the register
  p_zero_pos_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes && sumZero |=> resWord == '0);

  // R5: the normaliser always leaves a leading one for a nonzero sum
  p_norm_lead_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes && !sumZero |-> normSig[SIG_W-1]);

  // R7: truncation stores exactly the kept fraction bits
  p_trunc_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes && !strobes.roundNearest && !sumZero
      |=> resWord[MAN_W-1:0] == $past(normSig[SIG_W-2:GRS_W]));

endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRS_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 rndMode,
  input  logic                 inValid,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 outValid
);

  ctrlStrobe_t strobes;

  fpadd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rndMode  (rndMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fpadd_dp #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .GRS_W (GRS_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .resWord (result)
  );

endmodule

// File: tb/fpadd_top_tb_top.sv
`timescale 1ns/1ps
module fpadd_top_tb_top;

  localparam int W = 300;
  typedef logic [W-1:0] wide_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        rndMode = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] result;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] lastWord = '0;

  always #10 clk = ~clk;

  fpadd_top dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .rndMode(rndMode),
    .inValid(inValid), .result(result), .outValid(outValid)
  );

  // exact wide-integer reference: sum exactly, then round once
  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b,
                                         input logic mode);
    wide_t one, ma, mb, sA, sB, s, keep, rem, half;
    int ea, eb, base, p, sh, e;
    logic sg, up, found;
    one = 1;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    ma = (ea != 0) ? wide_t'({1'b1, a[22:0]}) : '0;
    mb = (eb != 0) ? wide_t'({1'b1, b[22:0]}) : '0;
    if (ma == 0 && mb == 0) return 32'h0;
    if (ma == 0) return b;
    if (mb == 0) return a;
    base = (ea < eb) ? ea : eb;
    sA = ma << (ea - base);
    sB = mb << (eb - base);
    if (a[31] == b[31]) begin s = sA + sB; sg = a[31]; end
    else if (sA > sB) begin s = sA - sB; sg = a[31]; end
    else if (sB > sA) begin s = sB - sA; sg = b[31]; end
    else return 32'h0;
    p = 0; found = 1'b0;
    for (int i = W - 1; i >= 0; i--) if (!found && s[i]) begin p = i; found = 1'b1; end
    if (p <= 23) begin
      s = s << (23 - p);
      e = base - (23 - p);
      return {sg, e[7:0], s[22:0]};
    end
    sh   = p - 23;
    keep = s >> sh;
    rem  = s & ((one << sh) - one);
    half = one << (sh - 1);
    up   = (mode == 1'b0) && ((rem > half) || (rem == half && keep[0]));
    keep = keep + wide_t'(up);
    e    = base + sh;
    if (keep[24]) begin keep = keep >> 1; e++; end
    return {sg, e[7:0], keep[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called on a falling edge; compares on the next falling edge
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic mode,
                       input string tag);
    logic [31:0] exp;
    exp = refAdd(a, b, mode);
    opA = a; opB = b; rndMode = mode; inValid = 1'b1;
    @(negedge clk);
    check("R10 valid", {31'b0, outValid}, 32'd1);
    check(tag, result, exp);
    lastWord = exp;
  endtask

  task automatic idleCycle(input logic [31:0] a, input logic [31:0] b);
    opA = a; opB = b; rndMode = ~rndMode; inValid = 1'b0;
    @(negedge clk);
    check("R10 idle valid", {31'b0, outValid}, 32'd0);
    check("R10 hold", result, lastWord);
  endtask

  function automatic logic [31:0] randOp();
    logic [7:0] ex;
    ex = 8'(110 + ($urandom % 30));
    return {1'($urandom), ex, 23'($urandom)};
  endfunction

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", {31'b0, outValid}, 32'd0);
    check("R11 reset result", result, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'h3F800000, 32'h40000000, 1'b0, "R1 fields 1+2");
    check("R1 value 3.0", result, 32'h40400000);
    runOp(32'h3FC00000, 32'h3FC00000, 1'b0, "R2 R5 carry 1.5+1.5");
    check("R5 carry exponent", result, 32'h40400000);
    runOp(32'hC0400000, 32'hC0000000, 1'b0, "R2 negative add");
    runOp(32'h40400000, 32'hBF800000, 1'b0, "R3 3-1");
    check("R3 value 2.0", result, 32'h40000000);
    runOp(32'h3F800000, 32'hC0400000, 1'b0, "R3 sign of larger");
    check("R3 value -2.0", result, 32'hC0000000);
    runOp(32'h3F800001, 32'hBF800000, 1'b0, "R5 leading zeros");
    check("R5 value ulp", result, 32'h34000000);
    runOp(32'h3F800000, 32'hB3800001, 1'b0, "R4 sticky nearest");
    check("R4 value", result, 32'h3F7FFFFF);
    runOp(32'h3F800000, 32'hB3800001, 1'b1, "R4 R7 sticky truncate");
    check("R7 value", result, 32'h3F7FFFFE);
    runOp(32'h3F800000, 32'h33800000, 1'b0, "R6 tie to even stays");
    check("R6 value even", result, 32'h3F800000);
    runOp(32'h3F800001, 32'h33800000, 1'b0, "R6 tie odd rounds up");
    check("R6 value up", result, 32'h3F800002);
    runOp(32'h4B000001, 32'h3F000000, 1'b0, "R6 R4 wide gap tie");
    check("R6 gap value", result, 32'h4B000002);
    runOp(32'h3F800001, 32'h33800000, 1'b1, "R7 truncate tie");
    check("R7 tie value", result, 32'h3F800001);
    runOp(32'hBF800001, 32'hB3C00000, 1'b1, "R7 negative truncate");
    check("R7 negative value", result, 32'hBF800001);
    runOp(32'h3FFFFFFF, 32'h33800000, 1'b0, "R8 round overflow");
    check("R8 value 2.0", result, 32'h40000000);
    runOp(32'h3FFFFFFF, 32'h33800000, 1'b1, "R8 no overflow truncate");
    runOp(32'h3F800000, 32'hBF800000, 1'b0, "R9 cancel");
    check("R9 +0 cancel", result, 32'h0);
    runOp(32'h80000000, 32'h80000000, 1'b0, "R9 -0 plus -0");
    check("R9 +0 neg zeros", result, 32'h0);
    runOp(32'h00000000, 32'hC0A00000, 1'b0, "R1 zero operand");
    check("R1 zero passthrough", result, 32'hC0A00000);
    idleCycle(32'h3F800000, 32'h3F800000);
    idleCycle(32'h40000000, 32'hC0000000);

    for (int n = 0; n < 400; n++) begin
      runOp(randOp(), randOp(), 1'($urandom), "R2 R3 R4 R6 R7 random");
      if (($urandom % 5) == 0) idleCycle(randOp(), randOp());
    end

    finish();
  end

endmodule